// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Entry and Return

This block holds the sixteen architectural registers that a processor core sees, together with its current status word and one saved status word for each exception mode. The current mode lives in the low five bits of the status word. It decides which physical register each register number selects. The block has two combinational read ports and one synchronous write port.

The block also handles the register side of exceptions. On an exception request it copies the status word into the saved status of the target mode and writes the return address into that mode's link register. It then switches the mode and sets the interrupt mask bits, all in one clock edge. On a flagged return it writes the current link register minus an offset into the program counter, and in the same edge it restores the status word from the current mode's saved copy. Instruction decode, the datapath and the choice between competing exceptions are handled outside this block.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word reads 0x000000D3: mode bits [4:0] are supervisor 10011, IRQ mask bit 7 is 1 and FIQ mask bit 6 is 1. Every register number reads 0 on both ports.
- R2: Registers 0 to 7 and register 15 (the program counter) are one physical set, shared by all modes.
- R3: Registers 8 to 12 have a private copy in FIQ mode (10001). All other modes share a single copy.
- R4: Registers 13 and 14 have a separate copy in each exception mode: FIQ 10001, IRQ 10010, supervisor 10011, abort 10111 and undefined 11011. User mode (10000) and system mode (11111) share one copy. Any other mode value is treated as user.
- R5: An exception request to an exception mode does the following in one edge. It copies the old status word into that mode's saved status. It writes the return address into that mode's register 14. It sets mode bits [4:0] to the target and sets bit 7. Bit 6 and bits 31..8 keep their old values unless R6 applies.
- R6: An exception request to FIQ mode also sets bit 6.
- R7: The saved-status read output shows the copy that belongs to the current mode. A saved-status write goes to the current mode's copy. In user or system mode the output reads 0 and writes are ignored.
- R8: A return request does two things in one edge: it sets register 15 to the current mode's register 14 minus the offset input, and it sets the status word to the current mode's saved status. In user or system mode a return request is ignored.
- R9: An accepted exception request blocks any return request, register write, status write or saved-status write in the same cycle. An accepted return blocks ordinary writes in the same cycle. Reads in the cycle after an entry see the new mode's registers.
- R10: An exception request whose target is not an exception mode is ignored, and ordinary writes in that cycle go ahead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ra_idx | input | 4 | Read port A register number |
| ra_data | output | DW | Read port A data |
| rb_idx | input | 4 | Read port B register number |
| rb_data | output | DW | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write number |
| wr_data | input | DW | Register write data |
| cpsr_wr_en | input | 1 | Status word write enable |
| cpsr_wr_data | input | DW | Status word write data |
| cpsr_out | output | DW | Current status word |
| spsr_wr_en | input | 1 | Saved-status write enable (current mode) |
| spsr_wr_data | input | DW | Saved-status write data |
| spsr_rd | output | DW | Saved status of the current mode |
| exc_req | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of the entry |
| exc_ret_addr | input | DW | Return address for the target link register |
| ret_req | input | 1 | Exception return request |
| ret_ofs | input | DW | Offset subtracted from the link register on return |

## Verification
The assertions check the following on every cycle: an entry sets the target mode and the IRQ mask, the saved status after an entry equals the previous status word, FIQ entry sets the FIQ mask, a return restores the saved status, the saved-status output is zero in the shared user bank, and an entry to a non-exception mode changes nothing. Some properties can only be shown by the bench's scenarios, because they need a chain of writes, mode changes and reads. These are: which physical copy each register number selects in each mode, that one bank's values survive a trip through another mode, the arithmetic on the program counter at return, and which request wins when several arrive in the same cycle.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [3:0]    rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          cpsr_wr_en,
  input  logic [DW-1:0] cpsr_wr_data,
  output logic [DW-1:0] cpsr_out,
  input  logic          spsr_wr_en,
  input  logic [DW-1:0] spsr_wr_data,
  output logic [DW-1:0] spsr_rd,
  input  logic          exc_req,
  input  logic [4:0]    exc_mode,
  input  logic [DW-1:0] exc_ret_addr,
  input  logic          ret_req,
  input  logic [DW-1:0] ret_ofs
);
  localparam int NBANK = 6;
  localparam int NLO   = 8;
  localparam int NHI   = 5;
  localparam logic [DW-1:0] RST_CPSR = DW'(32'h0000_00D3);

  logic [DW-1:0] lo_q   [NLO];
  logic [DW-1:0] hiu_q  [NHI];
  logic [DW-1:0] hif_q  [NHI];
  logic [DW-1:0] sp_q   [NBANK];
  logic [DW-1:0] lr_q   [NBANK];
  logic [DW-1:0] spsr_q [NBANK];
  logic [DW-1:0] pc_q;
  logic [DW-1:0] cpsr_q;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'b10001: return 3'd1;
      5'b10010: return 3'd2;
      5'b10011: return 3'd3;
      5'b10111: return 3'd4;
      5'b11011: return 3'd5;
      default:  return 3'd0;
    endcase
  endfunction

  logic [2:0] cur_bank, tgt_bank;
  logic       exc_ok, ret_ok, ord_ok;

  assign cur_bank = bank_of(cpsr_q[4:0]);
  assign tgt_bank = bank_of(exc_mode);
  assign exc_ok   = exc_req && (tgt_bank != 3'd0);
  assign ret_ok   = ret_req && (cur_bank != 3'd0) && !exc_ok;
  assign ord_ok   = !exc_ok && !ret_ok;
  assign cpsr_out = cpsr_q;
  assign spsr_rd  = (cur_bank == 3'd0) ? '0 : spsr_q[cur_bank];

  function automatic logic [DW-1:0] rd_reg(input logic [3:0] idx, input logic [2:0] bk);
    if (idx < 4'd8)       return lo_q[idx[2:0]];
    else if (idx < 4'd13) return (bk == 3'd1) ? hif_q[idx - 4'd8] : hiu_q[idx - 4'd8];
    else if (idx == 4'd13) return sp_q[bk];
    else if (idx == 4'd14) return lr_q[bk];
    else                  return pc_q;
  endfunction

  assign ra_data = rd_reg(ra_idx, cur_bank);
  assign rb_data = rd_reg(rb_idx, cur_bank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLO; i++) lo_q[i] <= '0;
      for (int i = 0; i < NHI; i++) begin
        hiu_q[i] <= '0;
        hif_q[i] <= '0;
      end
      for (int i = 0; i < NBANK; i++) begin
        sp_q[i]   <= '0;
        lr_q[i]   <= '0;
        spsr_q[i] <= '0;
      end
      pc_q   <= '0;
      cpsr_q <= RST_CPSR;
    end else if (exc_ok) begin
      spsr_q[tgt_bank] <= cpsr_q;
      lr_q[tgt_bank]   <= exc_ret_addr;
      cpsr_q[4:0]      <= exc_mode;
      cpsr_q[7]        <= 1'b1;
      if (tgt_bank == 3'd1) cpsr_q[6] <= 1'b1;
    end else if (ret_ok) begin
      pc_q   <= lr_q[cur_bank] - ret_ofs;
      cpsr_q <= spsr_q[cur_bank];
    end else if (ord_ok) begin
      if (wr_en) begin
        if (wr_idx < 4'd8) lo_q[wr_idx[2:0]] <= wr_data;
        else if (wr_idx < 4'd13) begin
          if (cur_bank == 3'd1) hif_q[wr_idx - 4'd8] <= wr_data;
          else                  hiu_q[wr_idx - 4'd8] <= wr_data;
        end
        else if (wr_idx == 4'd13) sp_q[cur_bank] <= wr_data;
        else if (wr_idx == 4'd14) lr_q[cur_bank] <= wr_data;
        else pc_q <= wr_data;
      end
      if (cpsr_wr_en) cpsr_q <= cpsr_wr_data;
      if (spsr_wr_en && cur_bank != 3'd0) spsr_q[cur_bank] <= spsr_wr_data;
    end
  end

  AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ok |=> (cpsr_q[4:0] == $past(exc_mode)) && cpsr_q[7]); // R5
  AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ok |=> spsr_rd == $past(cpsr_q)); // R5
  AST_FIQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ok && exc_mode == 5'b10001) |=> cpsr_q[6]); // R6
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> cpsr_q == $past(spsr_rd)); // R8
  AST_USER_SPSR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr_q[4:0] == 5'b10000 || cpsr_q[4:0] == 5'b11111) |-> spsr_rd == '0); // R7
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exc_ok && !ret_ok && !cpsr_wr_en) |=> cpsr_q == $past(cpsr_q)); // R10
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam int DW = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic [DW-1:0] ra_data, rb_data, wr_data = '0;
  logic wr_en = 1'b0, cpsr_wr_en = 1'b0, spsr_wr_en = 1'b0;
  logic [DW-1:0] cpsr_wr_data = '0, cpsr_out, spsr_wr_data = '0, spsr_rd;
  logic exc_req = 1'b0, ret_req = 1'b0;
  logic [4:0] exc_mode = '0;
  logic [DW-1:0] exc_ret_addr = '0, ret_ofs = '0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cpsr_wr_en(cpsr_wr_en), .cpsr_wr_data(cpsr_wr_data), .cpsr_out(cpsr_out),
    .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data), .spsr_rd(spsr_rd),
    .exc_req(exc_req), .exc_mode(exc_mode), .exc_ret_addr(exc_ret_addr),
    .ret_req(ret_req), .ret_ofs(ret_ofs)
  );

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; cpsr_wr_en = 1'b0; spsr_wr_en = 1'b0; exc_req = 1'b0; ret_req = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [DW-1:0] v);
    ra_idx = idx; rb_idx = idx;
    #1;
    v = ra_data;
    if (rb_data !== ra_data) chk("R2", "port B mismatch", rb_data, ra_data);
  endtask

  task automatic wreg(input logic [3:0] idx, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d; step();
  endtask

  task automatic wcpsr(input logic [DW-1:0] d);
    cpsr_wr_en = 1'b1; cpsr_wr_data = d; step();
  endtask

  task automatic enter(input logic [4:0] m, input logic [DW-1:0] a);
    exc_req = 1'b1; exc_mode = m; exc_ret_addr = a; step();
  endtask

  task automatic leave(input logic [DW-1:0] o);
    ret_req = 1'b1; ret_ofs = o; step();
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1", "status after reset", cpsr_out, 32'hD3);
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), v);
      chk("R1", "register after reset", v, '0);
    end
    chk("R1", "saved status after reset", spsr_rd, '0);
  endtask

  task automatic t_shared();
    logic [DW-1:0] v;
    wreg(4'd3, 32'h33); wreg(4'd15, 32'h1000); wreg(4'd13, 32'hAAA1);
    wcpsr(32'hD0);
    rd(4'd3, v);  chk("R2", "r3 shared svc->usr", v, 32'h33);
    rd(4'd15, v); chk("R2", "pc shared", v, 32'h1000);
    rd(4'd13, v); chk("R4", "user sp separate from svc", v, '0);
    wreg(4'd13, 32'hBB); wreg(4'd9, 32'h99);
    wcpsr(32'h1F);
    rd(4'd13, v); chk("R4", "system shares user sp", v, 32'hBB);
    chk("R7", "system saved status reads 0", spsr_rd, '0);
    spsr_wr_en = 1'b1; spsr_wr_data = 32'h5A5A; step();
    chk("R7", "system saved status write ignored", spsr_rd, '0);
  endtask

  task automatic t_irq();
    logic [DW-1:0] v;
    enter(5'b10010, 32'h2004);
    chk("R5", "irq status", cpsr_out, 32'h92);
    chk("R5", "irq saved status", spsr_rd, 32'h1F);
    rd(4'd14, v); chk("R5", "irq link", v, 32'h2004);
    rd(4'd13, v); chk("R4", "irq sp private", v, '0);
    rd(4'd9, v);  chk("R3", "irq shares r9", v, 32'h99);
    rd(4'd3, v);  chk("R9", "read after entry r3", v, 32'h33);
    spsr_wr_en = 1'b1; spsr_wr_data = 32'h1234; step();
    chk("R7", "irq saved status write", spsr_rd, 32'h1234);
    spsr_wr_en = 1'b1; spsr_wr_data = 32'h1F; step();
    leave(32'd4);
    rd(4'd15, v); chk("R8", "pc on irq return", v, 32'h2000);
    chk("R8", "status on irq return", cpsr_out, 32'h1F);
    rd(4'd13, v); chk("R4", "user sp kept", v, 32'hBB);
  endtask

  task automatic t_fiq();
    logic [DW-1:0] v;
    enter(5'b10001, 32'h3000);
    chk("R6", "fiq status", cpsr_out, 32'hD1);
    chk("R5", "fiq saved status", spsr_rd, 32'h1F);
    rd(4'd9, v); chk("R3", "fiq r9 private", v, '0);
    wreg(4'd9, 32'h55);
    rd(4'd9, v); chk("R3", "fiq r9 written", v, 32'h55);
    rd(4'd14, v); chk("R4", "fiq link", v, 32'h3000);
    leave(32'd4);
    chk("R8", "status on fiq return", cpsr_out, 32'h1F);
    rd(4'd15, v); chk("R8", "pc on fiq return", v, 32'h2FFC);
    rd(4'd9, v);  chk("R3", "user r9 untouched", v, 32'h99);
  endtask

  task automatic t_nested();
    enter(5'b10010, 32'h10);
    enter(5'b10111, 32'h20);
    chk("R5", "abort status", cpsr_out, 32'h97);
    chk("R7", "abort saved status", spsr_rd, 32'h92);
    leave(32'd0);
    chk("R7", "irq saved status retained", spsr_rd, 32'h1F);
    leave(32'd0);
    chk("R8", "back to system", cpsr_out, 32'h1F);
  endtask

  task automatic t_prio();
    logic [DW-1:0] v;
    exc_req = 1'b1; exc_mode = 5'b10011; exc_ret_addr = 32'h4000;
    ret_req = 1'b1; ret_ofs = 32'd8;
    wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'hDEAD;
    cpsr_wr_en = 1'b1; cpsr_wr_data = 32'h10;
    step();
    chk("R9", "entry wins status", cpsr_out, 32'h93);
    rd(4'd14, v); chk("R9", "svc link from entry", v, 32'h4000);
    chk("R9", "svc saved status", spsr_rd, 32'h1F);
    leave(32'd0);
    rd(4'd15, v); chk("R8", "pc from svc link", v, 32'h4000);
    rd(4'd14, v); chk("R9", "user link not written", v, '0);
  endtask

  task automatic t_bad();
    logic [DW-1:0] v;
    exc_req = 1'b1; exc_mode = 5'b10000; exc_ret_addr = 32'h77;
    wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h5;
    step();
    chk("R10", "bad target keeps status", cpsr_out, 32'h1F);
    rd(4'd14, v); chk("R10", "bad target keeps link", v, '0);
    rd(4'd5, v);  chk("R10", "write goes ahead", v, 32'h5);
    leave(32'd4);
    rd(4'd15, v); chk("R8", "return ignored in system", v, 32'h4000);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shared();
    t_irq();
    t_fiq();
    t_nested();
    t_prio();
    t_bad();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule